// File: doc/BRIEF.md
# Four-Channel DMA Bus Grant Arbiter

This block decides, cycle by cycle, who owns a shared bus: the CPU or one of four DMA channels. Each channel carries a 16-bit unit counter and a mode bit. A channel in single mode moves one unit per grant and then hands the bus back. A channel in block mode keeps the bus until its counter runs out. When the counter of a channel steps from 1 to 0, the block raises a one-cycle terminal-count pulse for that channel and disables it. The channel stays disabled until software loads a new count.

Arbitration uses fixed priority. Channel 0 is the highest and channel 3 the lowest. There is one timing exception. A request that rises while a single transfer completes, or in the CPU slot that follows, counts as a newcomer. A newcomer is served next, ahead of older pending requests of higher priority.

The controller has three states. ST_CPU means the CPU owns the bus and the arbiter looks for eligible requests. ST_DMA means one channel is granted. ST_GAP is the one CPU slot that is forced after every single-mode unit.

The transitions are:
- ST_CPU to ST_DMA when any eligible request exists.
- ST_DMA to ST_GAP when a single-mode unit completes.
- ST_DMA to ST_CPU when a block-mode channel reaches terminal count.
- ST_GAP to ST_DMA when a newcomer or another eligible request exists. Otherwise ST_GAP returns to ST_CPU.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is held and after it is released, cpu_gnt_o is 1, dma_gnt_o is 0 and tc_o is 0. Every channel is disabled.
- R2: In every cycle, exactly one of cpu_gnt_o and the four bits of dma_gnt_o is 1. Bit i of dma_gnt_o and bit i of tc_o belong to channel i.
- R3: In a CPU-owned slot, the lowest-numbered channel whose request is high and which is enabled receives the grant in the following cycle.
- R4: A channel whose mode_block_i bit is 0 (single mode) completes one unit per grant. After the xfer_done_i cycle, the CPU holds the bus for exactly one cycle. If the request is still high, the channel is granted again, until terminal count.
- R5: A channel whose mode_block_i bit is 1 (block mode) keeps the grant across successive xfer_done_i strobes until its terminal count. Requests from higher-priority channels during this time have no effect.
- R6: Every xfer_done_i strobe during a grant decrements that channel's counter. The step from 1 to 0 raises that channel's tc_o bit for exactly the next cycle and disables the channel. After that, its request is ignored.
- R7: A request of some channel can rise in the cycle in which a single-mode xfer_done_i is accepted, or in the CPU cycle right after it. That channel is granted next, even when a higher-priority request stays active. A rise at any other time gets no such precedence.
- R8: Writing a count of 0 through cnt_wr_i leaves the channel disabled. Its request is then ignored.
- R9: After a block-mode channel reaches terminal count, the CPU holds the bus for at least one cycle before any channel is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | DMA request per channel |
| mode_block_i | input | 4 | Per channel: 1 = block mode, 0 = single mode |
| cnt_wr_i | input | 4 | Per-channel strobe that loads cnt_wdata_i into the counter |
| cnt_wdata_i | input | 16 | Unit count to load; nonzero enables the channel |
| xfer_done_i | input | 1 | Datapath reports that the granted channel finished one unit |
| cpu_gnt_o | output | 1 | CPU owns the bus |
| dma_gnt_o | output | 4 | One-hot DMA grant |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
The assertions assume the following about the inputs:
- mode_block_i does not change while a channel holds the grant.
- xfer_done_i is high only in cycles where a DMA grant is visible.
- Counters are not reloaded for a channel that is currently granted.

The bench drives xfer_done_i only in cycles where it has just observed a grant. It sets the mode and loads the count before raising the request. It drops a request only after that channel's terminal count, so every stimulus stays inside these assumptions.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int unsigned DEF_NCH   = 4;
    localparam int unsigned DEF_CNT_W = 16;

    typedef enum logic [1:0] {
        ST_CPU = 2'd0,
        ST_DMA = 2'd1,
        ST_GAP = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dma_chan_counter.sv
module dma_chan_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             en_o,
    output logic             last_o,
    output logic             tc_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_o  <= 1'b0;
            tc_o  <= 1'b0;
        end else begin
            tc_o <= 1'b0;
            if (load_i) begin
                cnt_q <= load_val_i;
                en_o  <= (load_val_i != '0);
            end else if (dec_i && en_o) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    en_o <= 1'b0;
                    tc_o <= 1'b1;
                end
            end
        end
    end

    assign last_o = en_o && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int unsigned N = 4,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dma_req_watch.sv
module dma_req_watch #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         capture_i,
    input  logic         consume_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] ovr_o
);
    logic [N-1:0] req_q;
    logic [N-1:0] ovr_q;

    assign rise_o = req_i & ~req_q;
    assign ovr_o  = ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            ovr_q <= '0;
        end else begin
            req_q <= req_i;
            if (consume_i)      ovr_q <= '0;
            else if (capture_i) ovr_q <= ovr_q | rise_o;
        end
    end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NCH   = DEF_NCH,
    parameter int unsigned CNT_W = DEF_CNT_W,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_i,
    input  logic [NCH-1:0]   mode_block_i,
    input  logic [NCH-1:0]   cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             xfer_done_i,
    output logic             cpu_gnt_o,
    output logic [NCH-1:0]   dma_gnt_o,
    output logic [NCH-1:0]   tc_o
);
    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] owner_q, owner_d;

    logic [NCH-1:0] en_vec, last_vec, dec_vec;
    logic [NCH-1:0] eligible, rise_vec, ovr_vec, ovr_cand;
    logic           norm_valid, ovr_valid;
    logic [IDX_W-1:0] norm_idx, ovr_idx;
    logic           owner_block, owner_last, owner_en;
    logic           capture, consume;

    // per-channel counters
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign dec_vec[g] = (state_q == ST_DMA) && xfer_done_i && (owner_q == IDX_W'(g));
        dma_chan_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (cnt_wr_i[g]),
            .load_val_i (cnt_wdata_i),
            .dec_i      (dec_vec[g]),
            .en_o       (en_vec[g]),
            .last_o     (last_vec[g]),
            .tc_o       (tc_o[g])
        );
    end

    assign eligible    = req_i & en_vec;
    assign owner_block = mode_block_i[owner_q];
    assign owner_last  = last_vec[owner_q];
    assign owner_en    = en_vec[owner_q];

    // newcomer window: the single-unit done cycle and the gap slot after it
    assign capture = (state_q == ST_DMA) && xfer_done_i && !owner_block;
    assign consume = (state_q == ST_GAP);

    dma_req_watch #(.N(NCH)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .capture_i (capture),
        .consume_i (consume),
        .rise_o    (rise_vec),
        .ovr_o     (ovr_vec)
    );

    assign ovr_cand = (ovr_vec | rise_vec) & eligible;

    dma_prio_pick #(.N(NCH)) u_pick_norm (
        .req_i   (eligible),
        .valid_o (norm_valid),
        .idx_o   (norm_idx)
    );

    dma_prio_pick #(.N(NCH)) u_pick_ovr (
        .req_i   (ovr_cand),
        .valid_o (ovr_valid),
        .idx_o   (ovr_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CPU;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_CPU: begin
                if (norm_valid) begin
                    state_d = ST_DMA;
                    owner_d = norm_idx;
                end
            end
            ST_GAP: begin
                if (ovr_valid) begin
                    state_d = ST_DMA;
                    owner_d = ovr_idx;
                end else if (norm_valid) begin
                    state_d = ST_DMA;
                    owner_d = norm_idx;
                end else begin
                    state_d = ST_CPU;
                end
            end
            ST_DMA: begin
                if (xfer_done_i) begin
                    if (!owner_block)                  state_d = ST_GAP;
                    else if (owner_last || !owner_en)  state_d = ST_CPU;
                end
            end
            default: state_d = ST_CPU;
        endcase
    end

    // outputs
    always_comb begin
        cpu_gnt_o = (state_q != ST_DMA);
        dma_gnt_o = '0;
        if (state_q == ST_DMA) dma_gnt_o[owner_q] = 1'b1;
    end
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req_i,
    input logic [NCH-1:0] mode_block_i,
    input logic           xfer_done_i,
    input logic           cpu_gnt_o,
    input logic [NCH-1:0] dma_gnt_o,
    input logic [NCH-1:0] tc_o
);
    assert_one_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({cpu_gnt_o, dma_gnt_o}));

    assert_new_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_gnt_o && !$past(|dma_gnt_o)) |-> |($past(req_i) & dma_gnt_o));

    assert_single_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && |(dma_gnt_o & ~mode_block_i)) |=> (cpu_gnt_o && dma_gnt_o == '0));

    assert_block_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dma_gnt_o & mode_block_i) && !xfer_done_i) |=> (dma_gnt_o == $past(dma_gnt_o)));

    assert_tc_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_o) |=> (tc_o == '0));

    assert_tc_follows_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_o) |-> ($past(xfer_done_i) && $onehot0(tc_o)));

    assert_block_tc_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && |(dma_gnt_o & mode_block_i)) |=> (|tc_o) |-> cpu_gnt_o);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .mode_block_i (mode_block_i),
    .xfer_done_i  (xfer_done_i),
    .cpu_gnt_o    (cpu_gnt_o),
    .dma_gnt_o    (dma_gnt_o),
    .tc_o         (tc_o)
);

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_i = '0;
    logic [3:0]  mode_block_i = '0;
    logic [3:0]  cnt_wr_i = '0;
    logic [15:0] cnt_wdata_i = '0;
    logic        xfer_done_i = 1'b0;
    logic        cpu_gnt_o;
    logic [3:0]  dma_gnt_o;
    logic [3:0]  tc_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_bus_arbiter u_dma_bus_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .mode_block_i (mode_block_i),
        .cnt_wr_i     (cnt_wr_i),
        .cnt_wdata_i  (cnt_wdata_i),
        .xfer_done_i  (xfer_done_i),
        .cpu_gnt_o    (cpu_gnt_o),
        .dma_gnt_o    (dma_gnt_o),
        .tc_o         (tc_o)
    );

    // {channel[7:6], block[5], count[4:0]}
    localparam logic [7:0] VEC [6] = '{
        {2'd0, 1'b0, 5'd3},
        {2'd1, 1'b1, 5'd4},
        {2'd2, 1'b0, 5'd1},
        {2'd3, 1'b1, 5'd2},
        {2'd3, 1'b0, 5'd2},
        {2'd0, 1'b1, 5'd1}
    };

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 150000);
            report();
        end
    end

    task automatic load(input int ch, input int cnt);
        @(negedge clk);
        cnt_wr_i = 4'(1 << ch);
        cnt_wdata_i = 16'(cnt);
        @(negedge clk);
        cnt_wr_i = '0;
    endtask

    // service any grant for n cycles, checking single ownership every cycle
    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R2", $countones({cpu_gnt_o, dma_gnt_o}), 1);
            xfer_done_i = |dma_gnt_o;
        end
        xfer_done_i = 1'b0;
    endtask

    task automatic run_vec(input int ch, input bit blk, input int cnt);
        int units = 0;
        int gaps = 0;
        bit tc_seen = 1'b0;
        mode_block_i[ch] = blk;
        load(ch, cnt);
        req_i[ch] = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (tc_o[ch]) begin
                tc_seen = 1'b1;
                xfer_done_i = 1'b0;
                break;
            end
            if (dma_gnt_o == 4'(1 << ch)) begin
                units++;
                xfer_done_i = 1'b1;
            end else begin
                xfer_done_i = 1'b0;
                if (units > 0) gaps++;
            end
        end
        chk("R6 tc pulse", int'(tc_seen), 1);
        chk("R6 unit count", units, cnt);
        if (blk) chk("R5 no release in block", gaps, 0);
        else     chk("R4 one CPU slot per unit", gaps, cnt - 1);
        chk("R9/R4 CPU after last unit", int'(cpu_gnt_o), 1);
        @(negedge clk);
        chk("R6 tc one cycle", int'(tc_o[ch]), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 disabled after tc", int'(cpu_gnt_o), 1);
        end
        req_i[ch] = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 cpu in reset", int'(cpu_gnt_o), 1);
        chk("R1 dma in reset", int'(dma_gnt_o), 0);
        chk("R1 tc in reset", int'(tc_o), 0);
        rst_n = 1'b1;
        req_i = 4'b1111;
        repeat (3) @(negedge clk);
        chk("R1 channels disabled after reset", int'(cpu_gnt_o), 1);
        req_i = '0;

        // table walk
        foreach (VEC[i]) begin
            run_vec(int'(VEC[i][7:6]), VEC[i][5], int'(VEC[i][4:0]));
        end

        // R3: fixed priority
        mode_block_i = '0;
        load(1, 1);
        load(2, 1);
        req_i = 4'b0110;
        @(negedge clk);
        chk("R3 lowest index wins", int'(dma_gnt_o), 2);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        chk("R4 gap slot", int'(cpu_gnt_o), 1);
        @(negedge clk);
        chk("R3 next eligible", int'(dma_gnt_o), 4);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        req_i = '0;
        drain(4);

        // R7: rise in the done cycle
        load(0, 3);
        load(2, 1);
        req_i = 4'b0001;
        @(negedge clk);
        chk("R3 ch0 granted", int'(dma_gnt_o), 1);
        xfer_done_i = 1'b1;
        req_i[2] = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        chk("R4 gap before newcomer", int'(cpu_gnt_o), 1);
        @(negedge clk);
        chk("R7 newcomer in done cycle wins", int'(dma_gnt_o), 4);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        @(negedge clk);
        chk("R7 older request resumes", int'(dma_gnt_o), 1);
        drain(12);
        req_i = '0;

        // R7: rise in the gap cycle
        load(0, 3);
        load(3, 1);
        req_i = 4'b0001;
        @(negedge clk);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        req_i[3] = 1'b1;
        @(negedge clk);
        chk("R7 newcomer in gap cycle wins", int'(dma_gnt_o), 8);
        drain(12);
        req_i = '0;

        // R7: rise outside the window gets no precedence
        load(0, 3);
        load(2, 1);
        req_i = 4'b0001;
        @(negedge clk);
        req_i[2] = 1'b1;
        @(negedge clk);
        chk("R7 held grant", int'(dma_gnt_o), 1);
        xfer_done_i = 1'b1;
        @(negedge clk);
        xfer_done_i = 1'b0;
        @(negedge clk);
        chk("R7 no precedence outside window", int'(dma_gnt_o), 1);
        drain(14);
        req_i = '0;

        // R5 and R9: block ignores higher priority, then CPU slot
        mode_block_i = 4'b0100;
        load(2, 3);
        load(0, 1);
        req_i = 4'b0100;
        @(negedge clk);
        chk("R5 block granted", int'(dma_gnt_o), 4);
        req_i[0] = 1'b1;
        xfer_done_i = 1'b1;
        @(negedge clk);
        chk("R5 block holds vs ch0", int'(dma_gnt_o), 4);
        @(negedge clk);
        chk("R5 block holds to tc", int'(dma_gnt_o), 4);
        @(negedge clk);
        xfer_done_i = 1'b0;
        chk("R9 CPU after block tc", int'(cpu_gnt_o), 1);
        chk("R6 block tc", int'(tc_o), 4);
        @(negedge clk);
        chk("R9 then ch0", int'(dma_gnt_o), 1);
        drain(6);
        req_i = '0;
        mode_block_i = '0;

        // R8: zero count keeps channel disabled
        load(3, 0);
        req_i = 4'b1000;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 zero load ignored", int'(cpu_gnt_o), 1);
        end
        req_i = '0;

        finished = 1'b1;
        report();
    end
endmodule